// File: doc/BRIEF.md
# Traffic Light Sequencer with Dark Gaps

This block drives three single-bit lamp outputs, one each for red, yellow and green, from a free-running system clock. It walks through a fixed loop. One lamp is lit on its own for a full lamp period. All three lamps then go dark for half a lamp period. After that the next lamp comes on. The loop has six phases and repeats without end.

A prescaling counter turns clock cycles into the two interval lengths. The clock frequency and both intervals, given in tenths of a second, are parameters. A bench or a fast variant can therefore shrink the timing to a handful of cycles. A polarity parameter selects active-high or active-low lamp drive. The state register and the counter carry power-up values, so cycling begins without any reset. An optional synchronous reset sends the block back to the start of the red phase.

Top module: `traffic_sequencer`

## Requirements
- R1: Lit phases follow the cyclic order red, yellow, green, then red again, and every change of phase moves to the next of the six phases: red lit, dark, yellow lit, dark, green lit, dark.
- R2: Each lit phase lasts exactly ON_CYC = CLK_HZ/10*ON_TENTHS clock cycles (defaults: 27,000,000 cycles, one second at 27 MHz). The internal counter clears on every phase change, and the phase advances on the edge after the counter reaches ON_CYC-1.
- R3: Each dark gap lasts exactly GAP_CYC = CLK_HZ/10*GAP_TENTHS clock cycles (defaults: 13,500,000 cycles, half a second), and no lamp is lit during a gap.
- R4: At most one lamp is lit in any clock cycle.
- R5: Without any reset, the block starts in the red lit phase with its counter at zero, so red is lit for ON_CYC cycles from power-up.
- R6: The sequence repeats with a period of 3*ON_CYC + 3*GAP_CYC cycles (4.5 s by default) and never stops.
- R7: With ACTIVE_LOW = 0, a lit lamp drives 1 and a dark lamp drives 0. With ACTIVE_LOW = 1, every lamp output is the inverse of the active-high drive.
- R8: While rst is high at a clock edge, the block is forced to the red lit phase with its counter at zero. After rst falls, red stays lit for a full ON_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Optional synchronous reset, active high; tie low if unused |
| lamp_red | output | 1 | Red lamp drive, polarity set by ACTIVE_LOW |
| lamp_yellow | output | 1 | Yellow lamp drive, polarity set by ACTIVE_LOW |
| lamp_green | output | 1 | Green lamp drive, polarity set by ACTIVE_LOW |

## Verification
The main function is tried from three starting points: a cold start with no reset, free running across a full second cycle, and a reset asserted partway through the yellow phase and held for several cycles. The cold start tells a correct power-up state apart from one that relies on reset. The second cycle separates a true loop from a single pass. The mid-phase reset shows whether both the phase and the counter are cleared, rather than the phase alone. Run lengths are counted for every lit and dark pattern, so a phase that is off by one cycle, or one that is skipped or out of order, shows up. A second instance with inverted polarity is compared against the first on every cycle.

// File: rtl/tlseq_pkg.sv
package tlseq_pkg;

   typedef enum logic [2:0] {
      PH_RED_ON  = 3'd0,
      PH_RED_GAP = 3'd1,
      PH_YEL_ON  = 3'd2,
      PH_YEL_GAP = 3'd3,
      PH_GRN_ON  = 3'd4,
      PH_GRN_GAP = 3'd5
   } phase_e;

   localparam int unsigned NUM_PHASES = 6;

   function automatic phase_e next_phase(input phase_e cur);
      phase_e nxt;
      case (cur)
         PH_RED_ON:  nxt = PH_RED_GAP;
         PH_RED_GAP: nxt = PH_YEL_ON;
         PH_YEL_ON:  nxt = PH_YEL_GAP;
         PH_YEL_GAP: nxt = PH_GRN_ON;
         PH_GRN_ON:  nxt = PH_GRN_GAP;
         default:    nxt = PH_RED_ON;
      endcase
      return nxt;
   endfunction

   function automatic logic is_gap(input phase_e cur);
      return cur[0];
   endfunction

endpackage

// File: rtl/tlseq_interval_timer.sv
module tlseq_interval_timer #(
   parameter int unsigned ON_CYC  = 27_000_000,
   parameter int unsigned GAP_CYC = 13_500_000,
   parameter int unsigned CNT_W   = 25
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_gap,
   output logic             expire,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

   logic [CNT_W-1:0] cnt_q = '0;
   logic [CNT_W-1:0] last_val;

   generate
      if (ON_CYC == GAP_CYC) begin : g_single_limit
         assign last_val = ON_LAST;
      end else begin : g_dual_limit
         assign last_val = sel_gap ? GAP_LAST : ON_LAST;
      end
   endgenerate

   assign expire = (cnt_q == last_val);

   always_ff @(posedge clk) begin
      if (rst || expire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/tlseq_phase_fsm.sv
module tlseq_phase_fsm
   import tlseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   advance,
   output phase_e phase
);

   phase_e phase_q = PH_RED_ON;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_RED_ON;
      end else if (advance) begin
         phase_q <= next_phase(phase_q);
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/tlseq_lamp_decoder.sv
module tlseq_lamp_decoder
   import tlseq_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  phase_e phase,
   output logic   red,
   output logic   yellow,
   output logic   green
);

   logic [2:0] lit;

   always_comb begin
      lit = 3'b000;
      case (phase)
         PH_RED_ON: lit = 3'b100;
         PH_YEL_ON: lit = 3'b010;
         PH_GRN_ON: lit = 3'b001;
         default:   lit = 3'b000;
      endcase
   end

   generate
      if (ACTIVE_LOW) begin : g_drive_low
         assign {red, yellow, green} = ~lit;
      end else begin : g_drive_high
         assign {red, yellow, green} = lit;
      end
   endgenerate

endmodule

// File: rtl/traffic_sequencer.sv
module traffic_sequencer
   import tlseq_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 27_000_000,
   parameter int unsigned ON_TENTHS   = 10,
   parameter int unsigned GAP_TENTHS  = 5,
   parameter bit          ACTIVE_LOW  = 1'b0
) (
   input  logic clk,
   input  logic rst,
   output logic lamp_red,
   output logic lamp_yellow,
   output logic lamp_green
);

   localparam int unsigned ON_CYC  = (CLK_HZ / 10) * ON_TENTHS;
   localparam int unsigned GAP_CYC = (CLK_HZ / 10) * GAP_TENTHS;
   localparam int unsigned MAX_CYC = (ON_CYC > GAP_CYC) ? ON_CYC : GAP_CYC;
   localparam int unsigned CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

   generate
      if (CLK_HZ < 10) begin : g_bad_clk
         $error("traffic_sequencer: CLK_HZ must be at least 10");
      end
      if (ON_TENTHS == 0 || GAP_TENTHS == 0) begin : g_bad_interval
         $error("traffic_sequencer: interval lengths must be non-zero");
      end
   endgenerate

   phase_e           phase_q;
   logic             expire;
   logic [CNT_W-1:0] cnt_q;

   tlseq_interval_timer #(
      .ON_CYC  (ON_CYC),
      .GAP_CYC (GAP_CYC),
      .CNT_W   (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .sel_gap (is_gap(phase_q)),
      .expire  (expire),
      .cnt     (cnt_q)
   );

   tlseq_phase_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .advance (expire),
      .phase   (phase_q)
   );

   tlseq_lamp_decoder #(
      .ACTIVE_LOW (ACTIVE_LOW)
   ) u_decode (
      .phase  (phase_q),
      .red    (lamp_red),
      .yellow (lamp_yellow),
      .green  (lamp_green)
   );

endmodule

// File: rtl/tlseq_checker.sv
module tlseq_checker
   import tlseq_pkg::*;
#(
   parameter int unsigned ON_CYC     = 27_000_000,
   parameter int unsigned GAP_CYC    = 13_500_000,
   parameter int unsigned CNT_W      = 25,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             lamp_red,
   input logic             lamp_yellow,
   input logic             lamp_green,
   input phase_e           phase,
   input logic [CNT_W-1:0] cnt
);

   logic seen = 1'b0;
   always_ff @(posedge clk) seen <= 1'b1;

   logic [2:0]       lit;
   logic [CNT_W-1:0] last_val;

   assign lit      = ACTIVE_LOW ? ~{lamp_red, lamp_yellow, lamp_green}
                                : {lamp_red, lamp_yellow, lamp_green};
   assign last_val = is_gap(phase) ? CNT_W'(GAP_CYC - 1) : CNT_W'(ON_CYC - 1);

   p_one_lamp_r4: assert property (@(posedge clk) disable iff (rst || !seen)
      $onehot0(lit));

   p_gap_dark_r3: assert property (@(posedge clk) disable iff (rst || !seen)
      is_gap(phase) |-> lit == 3'b000);

   p_order_r1: assert property (@(posedge clk) disable iff (rst || !seen)
      (!$past(rst) && phase != $past(phase)) |-> phase == next_phase($past(phase)));

   p_clear_on_change_r2: assert property (@(posedge clk) disable iff (rst || !seen)
      (!$past(rst) && phase != $past(phase)) |-> cnt == '0);

   p_hold_until_last_r2: assert property (@(posedge clk) disable iff (rst || !seen)
      (!$past(rst) && $past(cnt) != $past(last_val)) |-> phase == $past(phase));

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst || !seen)
      cnt <= last_val);

   p_reset_start_r8: assert property (@(posedge clk) disable iff (!seen)
      rst |=> (phase == PH_RED_ON && cnt == '0));

endmodule

bind traffic_sequencer tlseq_checker #(
   .ON_CYC     (ON_CYC),
   .GAP_CYC    (GAP_CYC),
   .CNT_W      (CNT_W),
   .ACTIVE_LOW (ACTIVE_LOW)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .lamp_red    (lamp_red),
   .lamp_yellow (lamp_yellow),
   .lamp_green  (lamp_green),
   .phase       (phase_q),
   .cnt         (cnt_q)
);

// File: tb/traffic_sequencer_test.sv
module traffic_sequencer_test;

   localparam int unsigned CLK_HZ  = 40;
   localparam int          ON_CYC  = 40;
   localparam int          GAP_CYC = 20;
   localparam int          PERIOD  = 3 * ON_CYC + 3 * GAP_CYC;

   logic clk = 1'b0;
   logic rst = 1'b0;
   logic r_h, y_h, g_h;
   logic r_l, y_l, g_l;

   int n_chk  = 0;
   int n_fail = 0;
   int multi_lit = 0;
   int pol_err   = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   traffic_sequencer #(
      .CLK_HZ(CLK_HZ), .ON_TENTHS(10), .GAP_TENTHS(5), .ACTIVE_LOW(1'b0)
   ) uut (
      .clk(clk), .rst(rst),
      .lamp_red(r_h), .lamp_yellow(y_h), .lamp_green(g_h)
   );

   traffic_sequencer #(
      .CLK_HZ(CLK_HZ), .ON_TENTHS(10), .GAP_TENTHS(5), .ACTIVE_LOW(1'b1)
   ) uut_lo (
      .clk(clk), .rst(rst),
      .lamp_red(r_l), .lamp_yellow(y_l), .lamp_green(g_l)
   );

   function automatic logic [2:0] pat();
      return {r_h, y_h, g_h};
   endfunction

   always @(negedge clk) begin
      if ($countones(pat()) > 1) multi_lit++;
      if ({r_l, y_l, g_l} !== ~pat()) pol_err++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_len(input logic [2:0] p, output int n);
      n = 0;
      while (pat() == p && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic one_cycle(input string tag, output int total);
      int n;
      total = 0;
      run_len(3'b100, n); total += n; check(n == ON_CYC,  {tag, " R2 red length"},    n, ON_CYC);
      check(pat() == 3'b000, {tag, " R1 gap after red"}, int'(pat()), 0);
      run_len(3'b000, n); total += n; check(n == GAP_CYC, {tag, " R3 gap length"},    n, GAP_CYC);
      check(pat() == 3'b010, {tag, " R1 yellow next"}, int'(pat()), 2);
      run_len(3'b010, n); total += n; check(n == ON_CYC,  {tag, " R2 yellow length"}, n, ON_CYC);
      run_len(3'b000, n); total += n; check(n == GAP_CYC, {tag, " R3 gap length"},    n, GAP_CYC);
      check(pat() == 3'b001, {tag, " R1 green next"}, int'(pat()), 1);
      run_len(3'b001, n); total += n; check(n == ON_CYC,  {tag, " R2 green length"},  n, ON_CYC);
      run_len(3'b000, n); total += n; check(n == GAP_CYC, {tag, " R3 gap length"},    n, GAP_CYC);
      check(pat() == 3'b100, {tag, " R1 red after green"}, int'(pat()), 4);
   endtask

   task automatic t_powerup();
      int total;
      #1;
      check(pat() == 3'b100, "R5 red lit at power-up", int'(pat()), 4);
      one_cycle("R5 first cycle", total);
   endtask

   task automatic t_repeat();
      int total;
      one_cycle("R6 second cycle", total);
      check(total == PERIOD, "R6 full period", total, PERIOD);
   endtask

   task automatic t_midreset();
      int n;
      n = 0;
      while (pat() != 3'b010 && n < 1000) begin
         n++;
         @(negedge clk);
      end
      repeat (7) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(pat() == 3'b100, "R8 red during reset", int'(pat()), 4);
      repeat (9) @(negedge clk);
      check(pat() == 3'b100, "R8 held in red while reset", int'(pat()), 4);
      rst = 1'b0;
      run_len(3'b100, n);
      check(n == ON_CYC, "R8 full red after reset", n, ON_CYC);
      run_len(3'b000, n);
      check(n == GAP_CYC, "R3 gap after reset", n, GAP_CYC);
   endtask

   task automatic t_monitors();
      check(multi_lit == 0, "R4 more than one lamp lit", multi_lit, 0);
      check(pol_err == 0, "R7 active-low mismatch", pol_err, 0);
   endtask

   initial begin
      t_powerup();
      t_repeat();
      t_midreset();
      t_monitors();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule